// File: doc/BRIEF.md
# Programmable Register Cell with Selectable Clocking

This block is one storage cell of a sum-of-products logic fabric. A logic-array data term (and a second term for two-input flip-flop kinds) feeds a register whose behaviour is chosen by static configuration: plain data capture, toggle, J/K or set/reset. The register can be bypassed so that the output pin path carries the data term directly. The feedback path always carries the register's value.

The register is updated by one of three clock sources. The first is a selected global clock, used true or inverted. The second is the same global clock, with each update qualified by an active-high enable term. The third is an array clock formed by a logic term. All sources are sampled by a single system clock, and an update happens in the system cycle where the chosen source is first seen high. Term-driven preset and clear act at once, without waiting for a clock. A dedicated active-low global clear pin can be routed to the clear, cell by cell. The configuration is taken in while reset is held. After reset it stays fixed until the next reset.

Top module: `mcell_reg`

## Requirements
- R1: While `rst_n` is low and for the cycles after it until the first update, the register reads 0 on `fb_out`, and on `q_out` when the cell is not bypassed.
- R2: With `cfg_kind` = 0 (data), an update loads `da_term` into the register.
- R3: With `cfg_kind` = 1 (toggle), an update inverts the register when `da_term` is 1 and keeps it when `da_term` is 0.
- R4: With `cfg_kind` = 2 (J/K, J on `da_term`, K on `db_term`), an update holds on 00, clears on J=0 K=1, sets on J=1 K=0 and inverts on 11.
- R5: With `cfg_kind` = 3 (set/reset, S on `da_term`, R on `db_term`), an update sets on S only, clears on R only, and holds on both 00 and 11.
- R6: With `cfg_bypass` = 1, `q_out` equals `da_term` in the same cycle. `fb_out` still shows the register, which keeps running.
- R7: With `cfg_cmode` = 0, an update happens only on a rising edge of `gclk[cfg_gsel]` XOR `cfg_ginv`. An inverted clock thus updates on the pin's falling edge. Edges on the unselected global clock, and falling edges of the source, have no effect.
- R8: With `cfg_cmode` = 1, a source edge updates the register only when `ena_term` is 1 in that cycle.
- R9: With `cfg_cmode` = 2, only a rising edge of `aclk_term` updates the register. Global clock activity is ignored. Code 3 behaves as code 0.
- R10: `pre_term` = 1 drives `fb_out` to 1 at once, with no clock edge, and `clr_term` = 1 drives it to 0 at once. The register keeps the forced value after the term is released.
- R11: When preset and any clear are asserted together, clear wins and `fb_out` is 0.
- R12: With `cfg_gclr_en` = 1, `gclr_n` = 0 clears the cell at once, as `clr_term` does. With `cfg_gclr_en` = 0, `gclr_n` has no effect.
- R13: Configuration inputs are captured only while `rst_n` is low. Changing them after reset has no effect until the next reset.
- R14: A clock source that is already high when reset is released does not count as an edge. The first update needs the source to go low and then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all clock sources are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset; asynchronously clears the register, captures configuration |
| cfg_kind | input | 2 | Flip-flop kind: 0 data, 1 toggle, 2 J/K, 3 set/reset |
| cfg_bypass | input | 1 | 1 routes `da_term` straight to `q_out` |
| cfg_cmode | input | 2 | Clock mode: 0 global, 1 global with enable, 2 array term, 3 as 0 |
| cfg_gsel | input | GSEL_W | Index of the global clock used in modes 0 and 1 |
| cfg_ginv | input | 1 | 1 inverts the selected global clock |
| cfg_gclr_en | input | 1 | 1 routes the global clear pin into this cell |
| gclk | input | NUM_GCLK | Global clock lines |
| ena_term | input | 1 | Active-high update enable for mode 1 |
| aclk_term | input | 1 | Logic-term clock for mode 2 |
| da_term | input | 1 | Data / toggle / J / S term |
| db_term | input | 1 | K / R term |
| pre_term | input | 1 | Active-high immediate preset |
| clr_term | input | 1 | Active-high immediate clear |
| gclr_n | input | 1 | Active-low global clear pin |
| q_out | output | 1 | Output pin path (register or bypassed data) |
| fb_out | output | 1 | Feedback path (register value after preset/clear) |

## Verification
The bench builds the cell with two global clocks, so the select is one bit wide, and a reset value of 0. This small size lets it sweep the whole cube of flip-flop kind, starting state and both data terms, 32 cases, each computed from a next-state formula. The two-clock build also reaches both the selected and the unselected global clock, with and without inversion. The same build drives the enable, array-clock, bypass, preset/clear priority, global-clear routing and configuration-capture cases one by one.

// File: rtl/mcell_pkg.sv
`timescale 1ns/1ps
package mcell_pkg;

   typedef enum logic [1:0] {
      FF_DATA   = 2'd0,
      FF_TOGGLE = 2'd1,
      FF_JK     = 2'd2,
      FF_SR     = 2'd3
   } ff_kind_e;

   typedef enum logic [1:0] {
      CK_GLOBAL = 2'd0,
      CK_GATED  = 2'd1,
      CK_ARRAY  = 2'd2,
      CK_SPARE  = 2'd3
   } ck_mode_e;

   typedef struct packed {
      ff_kind_e kind;
      logic     bypass;
      ck_mode_e cmode;
      logic     ginv;
      logic     gclr_en;
   } cell_cfg_t;

endpackage

// File: rtl/mcell_cfgcap.sv
`timescale 1ns/1ps
// Holds the cell configuration; loads only while reset is asserted.
module mcell_cfgcap
   import mcell_pkg::*;
#(
   parameter int GSEL_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cell_cfg_t         cfg_in,
   input  logic [GSEL_W-1:0] gsel_in,
   output cell_cfg_t         cfg_q,
   output logic [GSEL_W-1:0] gsel_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= cfg_in;
         gsel_q <= gsel_in;
      end
   end

endmodule

// File: rtl/mcell_clksel.sv
`timescale 1ns/1ps
// Picks the clock source and turns it into a one-cycle update strobe.
module mcell_clksel
   import mcell_pkg::*;
#(
   parameter int NUM_GCLK = 2,
   parameter int GSEL_W   = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  ck_mode_e            cmode,
   input  logic [GSEL_W-1:0]   gsel,
   input  logic                ginv,
   input  logic [NUM_GCLK-1:0] gclk,
   input  logic                ena_term,
   input  logic                aclk_term,
   output logic                upd
);

   logic g_pick;
   logic src;
   logic src_prev;
   logic rise;

   generate
      if (NUM_GCLK == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^gsel;
         assign g_pick     = gclk[0];
      end else begin : g_multi
         logic [NUM_GCLK-1:0] hit;
         for (genvar i = 0; i < NUM_GCLK; i++) begin : g_line
            assign hit[i] = (gsel == GSEL_W'(i)) & gclk[i];
         end
         assign g_pick = |hit;
      end
   endgenerate

   always_comb begin
      if (cmode == CK_ARRAY) src = aclk_term;
      else                   src = g_pick ^ ginv;
   end

   // Held high through reset so a source already high is not an edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_prev <= 1'b1;
      else        src_prev <= src;
   end

   assign rise = src & ~src_prev;

   always_comb begin
      if (cmode == CK_GATED) upd = rise & ena_term;
      else                   upd = rise;
   end

endmodule

// File: rtl/mcell_next.sv
`timescale 1ns/1ps
// Next-state function for the four flip-flop kinds.
module mcell_next
   import mcell_pkg::*;
(
   input  ff_kind_e kind,
   input  logic     q,
   input  logic     ta,
   input  logic     tb,
   output logic     nxt
);

   always_comb begin
      unique case (kind)
         FF_DATA:   nxt = ta;
         FF_TOGGLE: nxt = q ^ ta;
         FF_JK: begin
            unique case ({ta, tb})
               2'b00:   nxt = q;
               2'b01:   nxt = 1'b0;
               2'b10:   nxt = 1'b1;
               default: nxt = ~q;
            endcase
         end
         default: begin
            unique case ({ta, tb})
               2'b01:   nxt = 1'b0;
               2'b10:   nxt = 1'b1;
               default: nxt = q;
            endcase
         end
      endcase
   end

endmodule

// File: rtl/mcell_reg.sv
`timescale 1ns/1ps
// Programmable register cell: four kinds, three clock modes, bypass,
// immediate preset/clear and routable global clear.
module mcell_reg
   import mcell_pkg::*;
#(
   parameter int NUM_GCLK = 2,
   parameter bit Q_RESET  = 1'b0,
   localparam int GSEL_W  = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          cfg_kind,
   input  logic                cfg_bypass,
   input  logic [1:0]          cfg_cmode,
   input  logic [GSEL_W-1:0]   cfg_gsel,
   input  logic                cfg_ginv,
   input  logic                cfg_gclr_en,
   input  logic [NUM_GCLK-1:0] gclk,
   input  logic                ena_term,
   input  logic                aclk_term,
   input  logic                da_term,
   input  logic                db_term,
   input  logic                pre_term,
   input  logic                clr_term,
   input  logic                gclr_n,
   output logic                q_out,
   output logic                fb_out
);

   generate
      if (NUM_GCLK < 1 || NUM_GCLK > 16) begin : g_bad_gclk
         $error("mcell_reg: NUM_GCLK must be within 1..16");
      end
   endgenerate

   cell_cfg_t         cfg_in;
   cell_cfg_t         cfg_q;
   logic [GSEL_W-1:0] gsel_q;
   logic              upd;
   logic              nxt;
   logic              q_reg;
   logic              clr_any;
   logic              force_on;
   logic              q_eff;

   assign cfg_in.kind    = ff_kind_e'(cfg_kind);
   assign cfg_in.bypass  = cfg_bypass;
   assign cfg_in.cmode   = ck_mode_e'(cfg_cmode);
   assign cfg_in.ginv    = cfg_ginv;
   assign cfg_in.gclr_en = cfg_gclr_en;

   mcell_cfgcap #(.GSEL_W(GSEL_W)) u_cfgcap (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_in  (cfg_in),
      .gsel_in (cfg_gsel),
      .cfg_q   (cfg_q),
      .gsel_q  (gsel_q)
   );

   mcell_clksel #(.NUM_GCLK(NUM_GCLK), .GSEL_W(GSEL_W)) u_clksel (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmode     (cfg_q.cmode),
      .gsel      (gsel_q),
      .ginv      (cfg_q.ginv),
      .gclk      (gclk),
      .ena_term  (ena_term),
      .aclk_term (aclk_term),
      .upd       (upd)
   );

   mcell_next u_next (
      .kind (cfg_q.kind),
      .q    (q_reg),
      .ta   (da_term),
      .tb   (db_term),
      .nxt  (nxt)
   );

   // Clear has priority over preset.
   assign clr_any  = clr_term | (cfg_q.gclr_en & ~gclr_n);
   assign force_on = clr_any | pre_term;
   assign q_eff    = clr_any ? 1'b0 : (pre_term ? 1'b1 : q_reg);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_reg <= Q_RESET;
      else if (force_on) q_reg <= q_eff;
      else if (upd)      q_reg <= nxt;
   end

   assign fb_out = q_eff;
   assign q_out  = cfg_q.bypass ? da_term : q_eff;

endmodule

// File: rtl/mcell_reg_chk.sv
`timescale 1ns/1ps
module mcell_reg_chk
   import mcell_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input cell_cfg_t cfg_live,
   input logic      pre_term,
   input logic      clr_term,
   input logic      gclr_n,
   input logic      da_term,
   input logic      aclk_term,
   input logic      q_out,
   input logic      fb_out
);

   logic ac_seen;
   logic pin_clr;
   logic any_force;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ac_seen <= 1'b1;
      else        ac_seen <= aclk_term;
   end

   assign pin_clr   = cfg_live.gclr_en & ~gclr_n;
   assign any_force = pre_term | clr_term | pin_clr;

   AST_BYPASS_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_live.bypass |-> (q_out == da_term)); // R6

   AST_PRESET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_term && !clr_term && !pin_clr) |-> fb_out); // R10

   AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_term || pin_clr) |-> !fb_out); // R11

   AST_GCLR_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      pin_clr |-> !fb_out); // R12

   AST_ARRAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_live.cmode == CK_ARRAY) && !(aclk_term && !ac_seen) && !any_force)
      |=> (any_force || $stable(fb_out))); // R9

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(cfg_live)); // R13

endmodule

bind mcell_reg mcell_reg_chk u_mcell_reg_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_live  (cfg_q),
   .pre_term  (pre_term),
   .clr_term  (clr_term),
   .gclr_n    (gclr_n),
   .da_term   (da_term),
   .aclk_term (aclk_term),
   .q_out     (q_out),
   .fb_out    (fb_out)
);

// File: tb/test_mcell_reg.sv
`timescale 1ns/1ps
module test_mcell_reg;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_kind = 2'd0;
   logic       cfg_bypass = 1'b0;
   logic [1:0] cfg_cmode = 2'd0;
   logic [0:0] cfg_gsel = 1'b0;
   logic       cfg_ginv = 1'b0;
   logic       cfg_gclr_en = 1'b0;
   logic [1:0] gclk = 2'b00;
   logic       ena_term = 1'b0;
   logic       aclk_term = 1'b0;
   logic       da_term = 1'b0;
   logic       db_term = 1'b0;
   logic       pre_term = 1'b0;
   logic       clr_term = 1'b0;
   logic       gclr_n = 1'b1;
   logic       q_out;
   logic       fb_out;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   mcell_reg #(.NUM_GCLK(2)) i_mcell_reg (
      .clk(clk), .rst_n(rst_n), .cfg_kind(cfg_kind), .cfg_bypass(cfg_bypass),
      .cfg_cmode(cfg_cmode), .cfg_gsel(cfg_gsel), .cfg_ginv(cfg_ginv),
      .cfg_gclr_en(cfg_gclr_en), .gclk(gclk), .ena_term(ena_term),
      .aclk_term(aclk_term), .da_term(da_term), .db_term(db_term),
      .pre_term(pre_term), .clr_term(clr_term), .gclr_n(gclr_n),
      .q_out(q_out), .fb_out(fb_out)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic apply_reset(input logic [1:0] kind, input logic [1:0] cmode,
                              input logic byp, input logic gsel,
                              input logic ginv, input logic gce);
      cfg_kind = kind; cfg_cmode = cmode; cfg_bypass = byp;
      cfg_gsel = gsel; cfg_ginv = ginv; cfg_gclr_en = gce;
      rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic force_q(input logic v);
      if (v) pre_term = 1'b1; else clr_term = 1'b1;
      tick();
      pre_term = 1'b0; clr_term = 1'b0;
   endtask

   task automatic gpulse0();
      gclk[0] = 1'b1; tick();
      gclk[0] = 1'b0; tick();
   endtask

   function automatic logic exp_next(input int kind, input logic q,
                                     input logic a, input logic b);
      case (kind)
         0:       return a;
         1:       return q ^ a;
         2:       return (a & ~q) | (~b & q);
         default: return (a & ~b) | (q & (a == b));
      endcase
   endfunction

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      string tags[4] = '{"R2", "R3", "R4", "R5"};
      // R1: reset state
      tick();
      chk("R1 fb in reset", fb_out, 1'b0);
      apply_reset(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R1 fb after reset", fb_out, 1'b0);
      chk("R1 q after reset", q_out, 1'b0);

      // R2..R5: exhaustive kind x state x inputs sweep
      for (int k = 0; k < 4; k++) begin
         apply_reset(2'(k), 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
         for (int q0 = 0; q0 < 2; q0++)
            for (int a = 0; a < 2; a++)
               for (int b = 0; b < 2; b++) begin
                  force_q(1'(q0));
                  da_term = 1'(a); db_term = 1'(b);
                  gpulse0();
                  chk(tags[k], fb_out, exp_next(k, 1'(q0), 1'(a), 1'(b)));
               end
      end
      da_term = 1'b0; db_term = 1'b0;

      // R7: unselected clock ignored, no update without an edge
      apply_reset(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      force_q(1'b0);
      da_term = 1'b1;
      gclk[1] = 1'b1; tick(); gclk[1] = 1'b0; tick();
      chk("R7 other clock ignored", fb_out, 1'b0);
      tick();
      chk("R7 no edge no update", fb_out, 1'b0);

      // R7: inverted selected clock updates on pin falling edge
      gclk = 2'b11;
      apply_reset(2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
      force_q(1'b0);
      da_term = 1'b1;
      gclk[0] = 1'b0; tick(); gclk[0] = 1'b1; tick();
      chk("R7 gclk0 ignored when gsel=1", fb_out, 1'b0);
      gclk[1] = 1'b0; tick();
      chk("R7 inverted falling edge updates", fb_out, 1'b1);
      da_term = 1'b0;
      gclk[1] = 1'b1; tick();
      chk("R7 inverted rising edge no update", fb_out, 1'b1);
      gclk = 2'b00;

      // R8: gated mode
      apply_reset(2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
      force_q(1'b0);
      da_term = 1'b1; ena_term = 1'b0;
      gpulse0();
      chk("R8 enable low blocks", fb_out, 1'b0);
      ena_term = 1'b1;
      gpulse0();
      chk("R8 enable high updates", fb_out, 1'b1);
      ena_term = 1'b0;

      // R9: array clock mode
      apply_reset(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
      force_q(1'b0);
      da_term = 1'b1;
      gpulse0();
      chk("R9 global clock ignored", fb_out, 1'b0);
      aclk_term = 1'b1; tick(); aclk_term = 1'b0; tick();
      chk("R9 array edge updates", fb_out, 1'b1);
      // R9: code 3 acts as global
      apply_reset(2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
      force_q(1'b0);
      da_term = 1'b1;
      aclk_term = 1'b1; tick(); aclk_term = 1'b0; tick();
      chk("R9 spare code ignores array clock", fb_out, 1'b0);
      gpulse0();
      chk("R9 spare code uses global", fb_out, 1'b1);

      // R6: bypass
      apply_reset(2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
      force_q(1'b0);
      da_term = 1'b1; #1;
      chk("R6 bypass follows data", q_out, 1'b1);
      chk("R6 feedback keeps register", fb_out, 1'b0);
      da_term = 1'b0; #1;
      chk("R6 bypass follows data low", q_out, 1'b0);
      tick();
      da_term = 1'b1;
      gpulse0();
      chk("R6 register runs in bypass", fb_out, 1'b1);

      // R10, R11, R12: immediate preset/clear
      apply_reset(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
      da_term = 1'b0;
      force_q(1'b0);
      pre_term = 1'b1; #1;
      chk("R10 preset immediate", fb_out, 1'b1);
      tick(); pre_term = 1'b0; #1;
      chk("R10 preset held", fb_out, 1'b1);
      clr_term = 1'b1; #1;
      chk("R10 clear immediate", fb_out, 1'b0);
      tick(); clr_term = 1'b0; #1;
      chk("R10 clear held", fb_out, 1'b0);
      tick();
      pre_term = 1'b1; clr_term = 1'b1; #1;
      chk("R11 clear beats preset", fb_out, 1'b0);
      tick(); clr_term = 1'b0; #1;
      chk("R10 preset alone", fb_out, 1'b1);
      tick(); pre_term = 1'b0;
      gclr_n = 1'b0; #1;
      chk("R12 global clear routed", fb_out, 1'b0);
      pre_term = 1'b1; #1;
      chk("R11 global clear beats preset", fb_out, 1'b0);
      tick(); pre_term = 1'b0; gclr_n = 1'b1; #1;
      chk("R12 global clear held", fb_out, 1'b0);
      apply_reset(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      force_q(1'b1);
      gclr_n = 1'b0; #1;
      chk("R12 unrouted global clear ignored", fb_out, 1'b1);
      tick();
      chk("R12 unrouted global clear ignored later", fb_out, 1'b1);
      gclr_n = 1'b1;

      // R13: configuration captured during reset only
      apply_reset(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      cfg_kind = 2'd1; cfg_bypass = 1'b1;
      force_q(1'b1);
      da_term = 1'b1;
      gpulse0();
      chk("R13 kind change ignored", fb_out, 1'b1);
      da_term = 1'b0; #1;
      chk("R13 bypass change ignored", q_out, 1'b1);
      cfg_bypass = 1'b0;
      apply_reset(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      force_q(1'b1);
      da_term = 1'b1;
      gpulse0();
      chk("R13 new kind after reset", fb_out, 1'b0);

      // R14: source high through reset release is not an edge
      gclk[0] = 1'b1;
      apply_reset(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      da_term = 1'b1;
      tick(); tick();
      chk("R14 no edge at release", fb_out, 1'b0);
      gclk[0] = 1'b0; tick();
      gclk[0] = 1'b1; tick();
      chk("R14 first real edge", fb_out, 1'b1);
      gclk[0] = 1'b0;

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule